// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the controller clock into CAN bit timing. A programmable prescaler divides the clock into time quanta. Each nominal bit is a single synchronisation quantum, then a first timing segment that covers propagation delay and phase one, then a second timing segment. The block marks the sampling instant with a one-cycle strobe at the close of the first segment. It marks the transmit instant with a one-cycle strobe at the close of the synchronisation quantum.

All timing settings come from one packed configuration word. Each field holds its quantity minus one. The word is captured only while the controller is held in its reset mode, and bit generation is frozen for as long as that mode lasts. At run time, a receive-edge pulse triggers a soft resynchronisation, and a hard-sync pulse, used at start of frame, restarts the bit. A soft resynchronisation lengthens or shortens the current bit by no more than the programmed jump width.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the configuration is 4-quantum first segment, prescaler 1, jump width 1, 2-quantum second segment. While `resetMode` is high, `tqTick`, `samplePt` and `txPt` stay low, and `bitSeg` returns to 0 (sync) on the next clock.
- R2: `cfgWord` is captured on a clock where `cfgWe` and `resetMode` are both high. A `cfgWe` pulse while `resetMode` is low leaves the bit timing unchanged.
- R3: `tqTick` pulses once every BRP clocks. BRP = `cfgWord[17:8]` + 1, giving 1 to 1024.
- R4: A bit without resync lasts (1 + T1 + T2) quanta. `bitSeg` steps sync (0), first segment (1), second segment (2), then back to sync. T1 = `cfgWord[23:20]` + 1 and T2 = `cfgWord[2:0]` + 1.
- R5: A stored T1 below 4 quanta acts as 4, and a stored T2 of 1 quantum acts as 2.
- R6: `samplePt` is high only on the quantum tick that ends the first segment, and `txPt` only on the tick that ends the sync quantum. The two never coincide.
- R7: A `rxEdge` pulse seen in quantum q (counted from 0) of the first segment lengthens that segment by min(q + 1, SJW). SJW = `cfgWord[5:4]` + 1.
- R8: A `rxEdge` pulse seen in quantum q of the second segment shortens it by min(T2 - 1 - q, SJW). The segment never ends before the quantum in progress completes.
- R9: At most one soft resync is applied per bit; later edges in the same bit are ignored. An edge during the sync quantum has no effect and does not use up the bit's resync.
- R10: `hardSync` takes priority over `rxEdge`. It clears the prescaler, returns to the sync quantum and discards any pending adjustment, so `txPt` follows BRP clocks later.
- R11: After `resetMode` falls, generation starts at the sync quantum with the prescaler at zero. The first `txPt` comes BRP - 1 clocks after the first running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetMode | input | 1 | Controller reset mode: freezes timing, permits configuration |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWord | input | 24 | Packed timing word, fields stored minus one |
| hardSync | input | 1 | Start-of-frame edge pulse, restarts the bit |
| rxEdge | input | 1 | Recessive-to-dominant edge pulse for soft resync |
| tqTick | output | 1 | One-cycle pulse at the last clock of each time quantum |
| samplePt | output | 1 | Sampling-point strobe |
| txPt | output | 1 | Transmit-point strobe |
| bitSeg | output | 2 | Current segment: 0 sync, 1 first, 2 second |

## Verification
The three strobes are decoded from registered state and the present inputs. A resync edge therefore moves `samplePt` or the end of the second segment in the same cycle as the edge. A configuration write acts from the next clock. A hard sync yields `txPt` exactly BRP clocks later, and leaving reset mode yields it BRP - 1 clocks after the first running cycle. The bench keeps a behavioural model in step with the design, one cycle at a time. It drives inputs on the falling edge and compares all four outputs a quarter period later, before the next rising edge. Targeted checks measure the distance in clocks between successive `txPt` pulses, and from a `txPt` to the following `samplePt`. They compare each distance with the value the requirements give for that configuration and that edge position.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // field widths of the packed timing word
  localparam int BRP_W = 10;
  localparam int T1_W  = 4;
  localparam int T2_W  = 3;
  localparam int SJW_W = 2;
  // field positions (decoded by the datapath)
  localparam int T1_LSB  = 20;
  localparam int BRP_LSB = 8;
  localparam int SJW_LSB = 4;
  localparam int T2_LSB  = 0;
  localparam int CFG_W   = T1_LSB + T1_W;
  // legal lower bounds in quanta
  localparam int T1_MIN = 4;
  localparam int T2_MIN = 2;
  // counters must hold the longest lengthened first segment
  localparam int LEN_W = T1_W + 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_T1   = 2'd1,
    SEG_T2   = 2'd2
  } seg_e;

  typedef struct packed {
    logic [LEN_W-1:0] t1Len;
    logic [LEN_W-1:0] t2Len;
    logic [LEN_W-1:0] sjw;
  } timing_t;

  // control -> datapath strobes
  typedef struct packed {
    logic prescClr;
    logic qClr;
  } strobe_t;

  function automatic seg_e nextSeg(seg_e s);
    case (s)
      SEG_SYNC: return SEG_T1;
      SEG_T1:   return SEG_T2;
      default:  return SEG_SYNC;
    endcase
  endfunction
endpackage

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetMode,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  strobe_t          stb,
  output timing_t          tim,
  output logic             tqTick,
  output logic [LEN_W-1:0] qCnt
);
  logic [T1_W-1:0]  t1Fld;
  logic [BRP_W-1:0] brpFld;
  logic [SJW_W-1:0] sjwFld;
  logic [T2_W-1:0]  t2Fld;
  logic [BRP_W-1:0] prescCnt;
  logic [LEN_W-1:0] t1Raw, t2Raw;

  // configuration capture, gated by reset mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t1Fld  <= T1_W'(T1_MIN - 1);
      brpFld <= '0;
      sjwFld <= '0;
      t2Fld  <= T2_W'(T2_MIN - 1);
    end else if (cfgWe && resetMode) begin
      t1Fld  <= cfgWord[T1_LSB +: T1_W];
      brpFld <= cfgWord[BRP_LSB +: BRP_W];
      sjwFld <= cfgWord[SJW_LSB +: SJW_W];
      t2Fld  <= cfgWord[T2_LSB +: T2_W];
    end
  end

  // decode with clamping to the legal minimum
  always_comb begin
    t1Raw     = LEN_W'(t1Fld) + LEN_W'(1);
    t2Raw     = LEN_W'(t2Fld) + LEN_W'(1);
    tim.t1Len = (t1Raw < LEN_W'(T1_MIN)) ? LEN_W'(T1_MIN) : t1Raw;
    tim.t2Len = (t2Raw < LEN_W'(T2_MIN)) ? LEN_W'(T2_MIN) : t2Raw;
    tim.sjw   = LEN_W'(sjwFld) + LEN_W'(1);
  end

  // prescaler: one quantum is brpFld+1 clocks
  assign tqTick = !stb.prescClr && (prescCnt == brpFld);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              prescCnt <= '0;
    else if (stb.prescClr)  prescCnt <= '0;
    else if (tqTick)        prescCnt <= '0;
    else                    prescCnt <= prescCnt + BRP_W'(1);
  end

  // quantum counter within the current segment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          qCnt <= '0;
    else if (stb.qClr)  qCnt <= '0;
    else if (tqTick)    qCnt <= qCnt + LEN_W'(1);
  end

  // R2: timing fields only move in reset mode
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !$past(resetMode) |-> ($stable(t1Fld) && $stable(brpFld) && $stable(sjwFld) && $stable(t2Fld)));

  // R3: a tick always restarts the prescaler
  a_r3_tick_restart: assert property (@(posedge clk) disable iff (!rstN)
    tqTick |=> (prescCnt == '0));
endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetMode,
  input  logic             hardSync,
  input  logic             rxEdge,
  input  logic             tqTick,
  input  logic [LEN_W-1:0] qCnt,
  input  timing_t          tim,
  output strobe_t          stb,
  output seg_e             seg,
  output logic             samplePt,
  output logic             txPt
);
  logic [LEN_W-1:0] adj1, adj2;
  logic [LEN_W-1:0] errT1, errT2, stepT1, stepT2, ext, shr, t1Last, t2Eff;
  logic             resyncDone, edgeOk, inT1, inT2;
  logic             endSync, endT1, endT2, segEnd;

  assign inT1   = (seg == SEG_T1);
  assign inT2   = (seg == SEG_T2);
  assign edgeOk = rxEdge && !resyncDone && !resetMode && !hardSync && (inT1 || inT2);

  // phase error and the bounded correction
  always_comb begin
    errT1  = qCnt + LEN_W'(1);
    errT2  = tim.t2Len - qCnt - LEN_W'(1);
    stepT1 = (errT1 < tim.sjw) ? errT1 : tim.sjw;
    stepT2 = (errT2 < tim.sjw) ? errT2 : tim.sjw;
    ext    = (edgeOk && inT1) ? stepT1 : '0;
    shr    = (edgeOk && inT2) ? stepT2 : '0;
    t1Last = tim.t1Len + adj1 + ext - LEN_W'(1);
    t2Eff  = tim.t2Len - adj2 - shr;
  end

  assign endSync = tqTick && (seg == SEG_SYNC);
  assign endT1   = tqTick && inT1 && (qCnt == t1Last);
  assign endT2   = tqTick && inT2 && ((qCnt + LEN_W'(1)) >= t2Eff);
  assign segEnd  = endSync || endT1 || endT2;

  assign stb.prescClr = resetMode || hardSync;
  assign stb.qClr     = resetMode || hardSync || segEnd;
  assign samplePt     = endT1;
  assign txPt         = endSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg        <= SEG_SYNC;
      adj1       <= '0;
      adj2       <= '0;
      resyncDone <= 1'b0;
    end else if (resetMode || hardSync) begin
      seg        <= SEG_SYNC;
      adj1       <= '0;
      adj2       <= '0;
      resyncDone <= 1'b0;
    end else begin
      if (edgeOk) begin
        resyncDone <= 1'b1;
        adj1       <= adj1 + ext;
        adj2       <= adj2 + shr;
      end
      if (segEnd) begin
        seg <= nextSeg(seg);
        if (endT2) begin
          adj1       <= '0;
          adj2       <= '0;
          resyncDone <= 1'b0;
        end
      end
    end
  end

  // R4: without a restart the segment only advances in order
  a_r4_seg_order: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(resetMode) && !$past(hardSync) && (seg != $past(seg)))
      |-> (seg == nextSeg($past(seg))));

  // R6: sample and transmit strobes are disjoint
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(samplePt && txPt));

  // R7: lengthening bounded by jump width
  a_r7_ext_bound: assert property (@(posedge clk) disable iff (!rstN)
    adj1 <= tim.sjw);

  // R8: shortening bounded by jump width
  a_r8_shr_bound: assert property (@(posedge clk) disable iff (!rstN)
    adj2 <= tim.sjw);

  // R9: an accepted edge locks out further resync in the bit
  a_r9_one_resync: assert property (@(posedge clk) disable iff (!rstN)
    edgeOk |=> (resyncDone || seg == SEG_SYNC));

  // R10: hard sync restarts segment and quantum count
  a_r10_restart: assert property (@(posedge clk) disable iff (!rstN)
    (hardSync && !resetMode) |=> (seg == SEG_SYNC && qCnt == '0 && !resyncDone));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import bt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetMode,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             hardSync,
  input  logic             rxEdge,
  output logic             tqTick,
  output logic             samplePt,
  output logic             txPt,
  output logic [1:0]       bitSeg
);
  strobe_t          stb;
  timing_t          tim;
  logic [LEN_W-1:0] qCnt;
  seg_e             seg;

  bt_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .resetMode (resetMode),
    .cfgWe     (cfgWe),
    .cfgWord   (cfgWord),
    .stb       (stb),
    .tim       (tim),
    .tqTick    (tqTick),
    .qCnt      (qCnt)
  );

  bt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .resetMode (resetMode),
    .hardSync  (hardSync),
    .rxEdge    (rxEdge),
    .tqTick    (tqTick),
    .qCnt      (qCnt),
    .tim       (tim),
    .stb       (stb),
    .seg       (seg),
    .samplePt  (samplePt),
    .txPt      (txPt)
  );

  assign bitSeg = seg;

  // R1: no strobes while held in reset mode
  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    resetMode |-> (!tqTick && !samplePt && !txPt));

  // R11: leaving reset mode starts at the sync quantum
  a_r11_start_sync: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetMode) |-> (bitSeg == 2'd0));
endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetMode = 1'b1;
  logic        cfgWe = 1'b0;
  logic [23:0] cfgWord = '0;
  logic        hardSync = 1'b0;
  logic        rxEdge = 1'b0;
  logic        tqTick, samplePt, txPt;
  logic [1:0]  bitSeg;

  always #10 clk = ~clk;  // 50 MHz

  can_bit_timer u_dut (
    .clk(clk), .rstN(rstN), .resetMode(resetMode), .cfgWe(cfgWe),
    .cfgWord(cfgWord), .hardSync(hardSync), .rxEdge(rxEdge),
    .tqTick(tqTick), .samplePt(samplePt), .txPt(txPt), .bitSeg(bitSeg)
  );

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R1";
  int cyc = 0;
  int lastTx = 0, lastPeriod = 0, sampleOff = 0, lastTick = 0, tickGap = 0;
  bit sawTx = 0;

  // behavioural reference state
  logic [23:0] mCfg = 24'h300001;
  int mPresc = 0, mSeg = 0, mQ = 0, mAdj1 = 0, mAdj2 = 0;
  bit mDone = 0;

  function automatic logic [23:0] mk(int t1, int brp, int sjw, int t2);
    return 24'(((t1 - 1) << 20) | ((brp - 1) << 8) | ((sjw - 1) << 4) | (t2 - 1));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    int brp, t1, t2, sj, e, ext, shr;
    bit clr, tick, ok, eS, e1, e2;
    logic [23:0] nCfg;
    #5;
    brp = int'(mCfg[17:8]) + 1;
    t1  = int'(mCfg[23:20]) + 1; if (t1 < 4) t1 = 4;
    t2  = int'(mCfg[2:0]) + 1;   if (t2 < 2) t2 = 2;
    sj  = int'(mCfg[5:4]) + 1;
    clr  = resetMode || hardSync || !rstN;
    tick = !clr && (mPresc == brp - 1);
    ok   = rstN && rxEdge && !mDone && !resetMode && !hardSync && (mSeg == 1 || mSeg == 2);
    ext = 0; shr = 0;
    if (ok && mSeg == 1) begin e = mQ + 1;      ext = (e < sj) ? e : sj; end
    if (ok && mSeg == 2) begin e = t2 - 1 - mQ; shr = (e < sj) ? e : sj; end
    eS = tick && mSeg == 0;
    e1 = tick && mSeg == 1 && (mQ == t1 + mAdj1 + ext - 1);
    e2 = tick && mSeg == 2 && (mQ + 1 >= t2 - mAdj2 - shr);
    nChecks++;
    if (tqTick !== tick || samplePt !== e1 || txPt !== eS || bitSeg !== 2'(mSeg)) begin
      nFail++;
      $display("FAIL %s cycle %0d: tick/sample/tx/seg actual %b %b %b %0d expected %b %b %b %0d",
               curReq, cyc, tqTick, samplePt, txPt, bitSeg, tick, e1, eS, mSeg);
    end
    if (txPt === 1'b1) begin lastPeriod = cyc - lastTx; lastTx = cyc; sawTx = 1; end
    if (samplePt === 1'b1) sampleOff = cyc - lastTx;
    if (tqTick === 1'b1) begin tickGap = cyc - lastTick; lastTick = cyc; end
    // next state
    nCfg = mCfg;
    if (!rstN) begin
      nCfg = 24'h300001; mPresc = 0; mSeg = 0; mQ = 0; mAdj1 = 0; mAdj2 = 0; mDone = 0;
    end else begin
      if (resetMode && cfgWe) nCfg = cfgWord;
      if (resetMode || hardSync) begin
        mPresc = 0; mSeg = 0; mQ = 0; mAdj1 = 0; mAdj2 = 0; mDone = 0;
      end else begin
        mPresc = tick ? 0 : mPresc + 1;
        if (ok) begin mDone = 1; mAdj1 += ext; mAdj2 += shr; end
        if (eS || e1 || e2) begin
          mQ = 0;
          mSeg = (mSeg + 1) % 3;
          if (e2) begin mAdj1 = 0; mAdj2 = 0; mDone = 0; end
        end else if (tick) mQ++;
      end
    end
    mCfg = nCfg;
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic nextTx();
    sawTx = 0;
    for (int g = 0; g < 4000 && !sawTx; g++) step();
  endtask

  task automatic waitState(int s, int q);
    for (int g = 0; g < 4000 && !(mSeg == s && mQ == q && mPresc == 0); g++) step();
  endtask

  task automatic pulseEdge();
    rxEdge = 1'b1; step(); rxEdge = 1'b0;
  endtask

  task automatic configure(logic [23:0] w);
    resetMode = 1'b1; cfgWord = w; cfgWe = 1'b1; step();
    cfgWe = 1'b0; step(); resetMode = 1'b0;
  endtask

  initial begin
    int hs, st;
    @(negedge clk);
    // R1 reset state
    curReq = "R1";
    repeat (3) step();
    rstN = 1'b1;
    repeat (2) step();
    chk(tqTick === 0 && samplePt === 0 && txPt === 0 && bitSeg === 0, "R1 idle in reset mode",
        int'({tqTick, samplePt, txPt}), 0);
    // R11 start with default config (BRP 1)
    curReq = "R11";
    resetMode = 1'b0; st = cyc;
    nextTx();
    chk(lastTx - st == 0, "R11 first txPt after leaving reset mode", lastTx - st, 0);
    // R4 default bit length 7
    curReq = "R4";
    nextTx();
    chk(lastPeriod == 7, "R4 default bit length", lastPeriod, 7);
    chk(sampleOff == 4, "R6 sample point after default T1", sampleOff, 4);
    // R3/R4/R6 programmed config
    curReq = "R3";
    configure(mk(6, 3, 2, 3));
    nextTx(); nextTx();
    chk(lastPeriod == 30, "R4 bit length 10 quanta x3", lastPeriod, 30);
    chk(sampleOff == 18, "R6 sample point after T1", sampleOff, 18);
    chk(tickGap == 3, "R3 quantum tick spacing", tickGap, 3);
    // R2 write ignored outside reset mode
    curReq = "R2";
    cfgWord = mk(16, 5, 4, 8); cfgWe = 1'b1; step(); cfgWe = 1'b0;
    nextTx(); nextTx();
    chk(lastPeriod == 30, "R2 write outside reset mode ignored", lastPeriod, 30);
    // R4 largest segments
    curReq = "R4";
    configure(mk(16, 4, 4, 8));
    nextTx(); nextTx();
    chk(lastPeriod == 100, "R4 max segments x4", lastPeriod, 100);
    // R5 clamping
    curReq = "R5";
    configure(24'h100000);
    nextTx(); nextTx();
    chk(lastPeriod == 7, "R5 clamped T1/T2", lastPeriod, 7);
    chk(sampleOff == 4, "R5 clamped T1 sample point", sampleOff, 4);
    // resync config: T1 8, BRP 2, SJW 2, T2 4 -> 26 clocks
    curReq = "R7";
    configure(mk(8, 2, 2, 4));
    nextTx(); nextTx();
    chk(lastPeriod == 26, "R4 nominal resync config", lastPeriod, 26);
    waitState(1, 0); pulseEdge(); nextTx();
    chk(lastPeriod == 28, "R7 lengthen by 1", lastPeriod, 28);
    nextTx(); waitState(1, 5); pulseEdge(); nextTx();
    chk(lastPeriod == 30, "R7 lengthen clamped to SJW", lastPeriod, 30);
    curReq = "R8";
    nextTx(); waitState(2, 0); pulseEdge(); nextTx();
    chk(lastPeriod == 22, "R8 shorten clamped to SJW", lastPeriod, 22);
    nextTx(); waitState(2, 2); pulseEdge(); nextTx();
    chk(lastPeriod == 24, "R8 shorten by 1", lastPeriod, 24);
    nextTx(); waitState(2, 3); pulseEdge(); nextTx();
    chk(lastPeriod == 26, "R8 edge in last quantum", lastPeriod, 26);
    curReq = "R9";
    nextTx(); waitState(1, 0); pulseEdge(); waitState(1, 3); pulseEdge(); nextTx();
    chk(lastPeriod == 28, "R9 second edge ignored", lastPeriod, 28);
    nextTx(); waitState(1, 0); pulseEdge(); waitState(2, 0); pulseEdge(); nextTx();
    chk(lastPeriod == 28, "R9 edge in T2 after T1 resync ignored", lastPeriod, 28);
    waitState(0, 0); pulseEdge(); nextTx(); waitState(1, 0); pulseEdge(); nextTx();
    chk(lastPeriod == 28, "R9 sync edge ignored and resync kept", lastPeriod, 28);
    // R10 hard sync
    curReq = "R10";
    nextTx(); waitState(1, 2);
    hardSync = 1'b1; hs = cyc; step(); hardSync = 1'b0;
    nextTx();
    chk(lastTx - hs == 2, "R10 txPt BRP clocks after hard sync", lastTx - hs, 2);
    waitState(1, 2);
    hardSync = 1'b1; rxEdge = 1'b1; hs = cyc; step(); hardSync = 1'b0; rxEdge = 1'b0;
    nextTx();
    chk(lastTx - hs == 2, "R10 hard sync wins over edge", lastTx - hs, 2);
    nextTx();
    chk(lastPeriod == 26, "R10 no adjustment kept", lastPeriod, 26);
    waitState(1, 0); pulseEdge(); waitState(1, 4);
    hardSync = 1'b1; step(); hardSync = 1'b0;
    nextTx(); nextTx();
    chk(lastPeriod == 26, "R10 pending lengthen discarded", lastPeriod, 26);
    // R11 re-entry
    curReq = "R11";
    waitState(2, 1);
    resetMode = 1'b1; repeat (3) step();
    chk(tqTick === 0 && bitSeg === 0, "R1 reset mode holds sync", int'(bitSeg), 0);
    resetMode = 1'b0; st = cyc;
    nextTx();
    chk(lastTx - st == 1, "R11 first txPt BRP-1 clocks after leaving", lastTx - st, 1);
    nextTx();
    chk(lastPeriod == 26, "R11 first full bit", lastPeriod, 26);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #4000000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule